// File: doc/BRIEF.md
# In-Group Store-Load Overlap Detector

This block keeps a short list of the stores that have been accepted into the dispatch group now being formed. It checks every load offered to the same group against all of them at once. A store is described by two address operand tags, an optional constant offset and an access size. The two tags are an offset-or-index operand and a base operand. A load carries the same fields. When a load would read bytes that a recorded store in the same group may have written, the block raises a noop hazard. The scheduler then closes the group or pads it with a no-op rather than risk a replay. The block does not compute real addresses and does not decode opcodes. Its upstream logic supplies the operand tags and the size code.

A small state machine tracks how full the store list is. It has three states. LST_EMPTY means no store is recorded. LST_PARTIAL means at least one entry is free and at least one is used. LST_FULL means every slot is taken. There are five transitions. T_FIRST goes from LST_EMPTY to LST_PARTIAL on the first store. T_ADD stays in LST_PARTIAL while a further store leaves room. T_FILL enters LST_FULL when a store takes the last slot. T_OVER stays in LST_FULL when a store arrives with no room: that store is dropped and the overflow flag is set. T_CLEAR returns to LST_EMPTY from any state when the group ends.

Top module: `hzd_group_overlap`

## Requirements
- R1: A valid load raises `noop_hazard` when both of its operand tags equal a recorded store's tags in the same position (offset tag with offset tag, base tag with base tag).
- R2: A valid load also raises `noop_hazard` when its offset tag equals a recorded store's base tag and its base tag equals that store's offset tag.
- R3: When the base tags are equal, both offsets are flagged constant and the store offset is strictly below the load offset, a hazard is raised exactly when the store offset plus the store size exceeds the load offset.
- R4: Under the same tag and constant conditions, when the store offset is not below the load offset, a hazard is raised exactly when the load offset plus the load size exceeds the store offset. This case includes equal offsets.
- R5: Size codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 are treated as 16 bytes.
- R6: `grp_end` empties the list and clears the overflow flag at the next clock edge. A store presented in the same cycle as `grp_end` belongs to the closing group and is not recorded.
- R7: `noop_hazard` is low whenever `ld_valid` is low or no store is recorded.
- R8: The list holds up to five stores. A store arriving when the list is full is not recorded, leaves `store_cnt` unchanged and sets `ovf_flag`.
- R9: `noop_hazard` is combinational and uses only stores recorded at earlier clock edges. A store presented in the same cycle as a load is not seen by that load.
- R10: After reset `store_cnt` is 0 and `ovf_flag` is low. Each recorded store raises `store_cnt` by one at the next edge.
- R11: No overlap is found when the base tags differ, when either offset is not constant, or when the byte ranges only touch without sharing a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_end | input | 1 | The current dispatch group closes at this edge |
| st_valid | input | 1 | A store is accepted into the group |
| st_off_tag | input | TAG_W | Store offset/index operand tag |
| st_base_tag | input | TAG_W | Store base operand tag |
| st_off_const | input | 1 | Store offset operand is a constant |
| st_off_val | input | OFF_W | Store constant offset value |
| st_size | input | 3 | Store size code (R5) |
| ld_valid | input | 1 | A load is being checked |
| ld_off_tag | input | TAG_W | Load offset/index operand tag |
| ld_base_tag | input | TAG_W | Load base operand tag |
| ld_off_const | input | 1 | Load offset operand is a constant |
| ld_off_val | input | OFF_W | Load constant offset value |
| ld_size | input | 3 | Load size code (R5) |
| noop_hazard | output | 1 | Load conflicts with a recorded store |
| ovf_flag | output | 1 | A store was dropped because the list was full |
| store_cnt | output | CNT_W | Number of stores recorded in this group |

## Verification
Three pairs of events can fall in the same cycle. A store can arrive together with the group end. A store can arrive together with a load that targets the same bytes. A sixth store can arrive while a load is checked against the full list. The directed tasks drive each pair on one falling edge. For the store and group end, the bench expects the store to be lost and the count to be zero afterwards. For the store and load, it expects no hazard in that cycle and a hazard one cycle later. For the overflow store, it expects the count to stay at five, the flag to rise, and a later load aimed only at the dropped store to see no hazard.

// File: rtl/hzd_overlap_pkg.sv
package hzd_overlap_pkg;

    localparam int SZ_CODE_W = 3;
    localparam int SZ_BYTE_W = 5;

    typedef enum logic [1:0] {
        LST_EMPTY   = 2'd0,
        LST_PARTIAL = 2'd1,
        LST_FULL    = 2'd2
    } hzd_lst_state_e;

    // size code to byte count; codes above 4 saturate at 16 bytes
    function automatic logic [SZ_BYTE_W-1:0] hzd_size_bytes(input logic [SZ_CODE_W-1:0] code);
        logic [SZ_BYTE_W-1:0] b;
        if (code > 3'd4) b = 5'd16;
        else             b = 5'd1 << code;
        return b;
    endfunction

endpackage

// File: rtl/hzd_entry_cmp.sv
module hzd_entry_cmp
    import hzd_overlap_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int OFF_W = 16
) (
    input  logic                 ent_vld,
    input  logic [TAG_W-1:0]     st_off_tag,
    input  logic [TAG_W-1:0]     st_base_tag,
    input  logic                 st_const,
    input  logic [OFF_W-1:0]     st_off,
    input  logic [SZ_CODE_W-1:0] st_size,
    input  logic [TAG_W-1:0]     ld_off_tag,
    input  logic [TAG_W-1:0]     ld_base_tag,
    input  logic                 ld_const,
    input  logic [OFF_W-1:0]     ld_off,
    input  logic [SZ_CODE_W-1:0] ld_size,
    output logic                 hit
);
    localparam int SUM_W = OFF_W + 1;

    logic             same_order;
    logic             swapped;
    logic             base_eq;
    logic             both_const;
    logic [SUM_W-1:0] st_end;
    logic [SUM_W-1:0] ld_end;
    logic             range_hit;

    always_comb begin
        same_order = (st_off_tag == ld_off_tag) && (st_base_tag == ld_base_tag);
        swapped    = (ld_off_tag == st_base_tag) && (ld_base_tag == st_off_tag);
        base_eq    = (st_base_tag == ld_base_tag);
        both_const = st_const && ld_const;
        st_end     = {1'b0, st_off} + SUM_W'(hzd_size_bytes(st_size));
        ld_end     = {1'b0, ld_off} + SUM_W'(hzd_size_bytes(ld_size));
        if (st_off < ld_off) range_hit = (st_end > {1'b0, ld_off});
        else                 range_hit = (ld_end > {1'b0, st_off});
        hit = ent_vld && (same_order || swapped || (base_eq && both_const && range_hit));
    end

endmodule

// File: rtl/hzd_store_list.sv
module hzd_store_list
    import hzd_overlap_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int TAG_W = 6,
    parameter int OFF_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       grp_end,
    input  logic                       st_valid,
    input  logic [TAG_W-1:0]           st_off_tag,
    input  logic [TAG_W-1:0]           st_base_tag,
    input  logic                       st_off_const,
    input  logic [OFF_W-1:0]           st_off_val,
    input  logic [SZ_CODE_W-1:0]       st_size,
    output logic [DEPTH-1:0]           ent_vld,
    output logic [DEPTH-1:0][TAG_W-1:0]     ent_off_tag,
    output logic [DEPTH-1:0][TAG_W-1:0]     ent_base_tag,
    output logic [DEPTH-1:0]           ent_const,
    output logic [DEPTH-1:0][OFF_W-1:0]     ent_off,
    output logic [DEPTH-1:0][SZ_CODE_W-1:0] ent_size,
    output logic [CNT_W-1:0]           cnt,
    output logic                       ovf,
    output hzd_lst_state_e             state
);
    hzd_lst_state_e   state_nxt;
    logic             wr_en;
    logic             ovf_set;
    logic [CNT_W-1:0] cnt_nxt;

    // next state and write control
    always_comb begin
        state_nxt = state;
        wr_en     = 1'b0;
        ovf_set   = 1'b0;
        cnt_nxt   = cnt;
        if (grp_end) begin
            state_nxt = LST_EMPTY;                     // T_CLEAR
            cnt_nxt   = '0;
        end else if (st_valid) begin
            unique case (state)
                LST_EMPTY: begin                       // T_FIRST
                    wr_en     = 1'b1;
                    cnt_nxt   = CNT_W'(1);
                    state_nxt = (DEPTH == 1) ? LST_FULL : LST_PARTIAL;
                end
                LST_PARTIAL: begin                     // T_ADD or T_FILL
                    wr_en     = 1'b1;
                    cnt_nxt   = cnt + CNT_W'(1);
                    state_nxt = (cnt_nxt == CNT_W'(DEPTH)) ? LST_FULL : LST_PARTIAL;
                end
                LST_FULL: begin                        // T_OVER
                    ovf_set   = 1'b1;
                end
                default: state_nxt = LST_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LST_EMPTY;
        else        state <= state_nxt;
    end

    // count and overflow outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            if (grp_end)      ovf <= 1'b0;
            else if (ovf_set) ovf <= 1'b1;
        end
    end

    // entry storage, one slot per group position
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_off_tag[g]  <= '0;
                ent_base_tag[g] <= '0;
                ent_const[g]    <= 1'b0;
                ent_off[g]      <= '0;
                ent_size[g]     <= '0;
            end else if (wr_en && (cnt == CNT_W'(g))) begin
                ent_off_tag[g]  <= st_off_tag;
                ent_base_tag[g] <= st_base_tag;
                ent_const[g]    <= st_off_const;
                ent_off[g]      <= st_off_val;
                ent_size[g]     <= st_size;
            end
        end
        assign ent_vld[g] = (cnt > CNT_W'(g));
    end

endmodule

// File: rtl/hzd_group_overlap.sv
module hzd_group_overlap
    import hzd_overlap_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int TAG_W = 6,
    parameter int OFF_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grp_end,
    input  logic             st_valid,
    input  logic [TAG_W-1:0] st_off_tag,
    input  logic [TAG_W-1:0] st_base_tag,
    input  logic             st_off_const,
    input  logic [OFF_W-1:0] st_off_val,
    input  logic [2:0]       st_size,
    input  logic             ld_valid,
    input  logic [TAG_W-1:0] ld_off_tag,
    input  logic [TAG_W-1:0] ld_base_tag,
    input  logic             ld_off_const,
    input  logic [OFF_W-1:0] ld_off_val,
    input  logic [2:0]       ld_size,
    output logic             noop_hazard,
    output logic             ovf_flag,
    output logic [CNT_W-1:0] store_cnt
);
    logic [DEPTH-1:0]                ent_vld;
    logic [DEPTH-1:0][TAG_W-1:0]     ent_off_tag;
    logic [DEPTH-1:0][TAG_W-1:0]     ent_base_tag;
    logic [DEPTH-1:0]                ent_const;
    logic [DEPTH-1:0][OFF_W-1:0]     ent_off;
    logic [DEPTH-1:0][SZ_CODE_W-1:0] ent_size;
    logic [DEPTH-1:0]                ent_hit;
    hzd_lst_state_e                  lst_state;

    hzd_store_list #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_list (
        .clk          (clk),
        .rst_n        (rst_n),
        .grp_end      (grp_end),
        .st_valid     (st_valid),
        .st_off_tag   (st_off_tag),
        .st_base_tag  (st_base_tag),
        .st_off_const (st_off_const),
        .st_off_val   (st_off_val),
        .st_size      (st_size),
        .ent_vld      (ent_vld),
        .ent_off_tag  (ent_off_tag),
        .ent_base_tag (ent_base_tag),
        .ent_const    (ent_const),
        .ent_off      (ent_off),
        .ent_size     (ent_size),
        .cnt          (store_cnt),
        .ovf          (ovf_flag),
        .state        (lst_state)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        hzd_entry_cmp #(.TAG_W(TAG_W), .OFF_W(OFF_W)) u_cmp (
            .ent_vld     (ent_vld[g]),
            .st_off_tag  (ent_off_tag[g]),
            .st_base_tag (ent_base_tag[g]),
            .st_const    (ent_const[g]),
            .st_off      (ent_off[g]),
            .st_size     (ent_size[g]),
            .ld_off_tag  (ld_off_tag),
            .ld_base_tag (ld_base_tag),
            .ld_const    (ld_off_const),
            .ld_off      (ld_off_val),
            .ld_size     (ld_size),
            .hit         (ent_hit[g])
        );
    end

    always_comb begin
        noop_hazard = ld_valid && (lst_state != LST_EMPTY) && (|ent_hit);
    end

endmodule

// File: rtl/hzd_group_overlap_chk.sv
module hzd_group_overlap_chk #(
    parameter int DEPTH = 5,
    parameter int TAG_W = 6,
    parameter int OFF_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             grp_end,
    input logic             st_valid,
    input logic             ld_valid,
    input logic             noop_hazard,
    input logic             ovf_flag,
    input logic [CNT_W-1:0] store_cnt
);
    assert_clear_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grp_end |=> (store_cnt == '0) && !ovf_flag);

    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !grp_end && (store_cnt < CNT_W'(DEPTH)))
            |=> (store_cnt == $past(store_cnt) + CNT_W'(1)));

    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !grp_end && (store_cnt == CNT_W'(DEPTH)))
            |=> ovf_flag && (store_cnt == CNT_W'(DEPTH)));

    assert_no_load_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_valid || (store_cnt == '0)) |-> !noop_hazard);

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        store_cnt <= CNT_W'(DEPTH));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_valid && !grp_end) |=> $stable(store_cnt) && $stable(ovf_flag));
endmodule

bind hzd_group_overlap hzd_group_overlap_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grp_end     (grp_end),
    .st_valid    (st_valid),
    .ld_valid    (ld_valid),
    .noop_hazard (noop_hazard),
    .ovf_flag    (ovf_flag),
    .store_cnt   (store_cnt)
);

// File: tb/test_hzd_group_overlap.sv
`timescale 1ns/1ps
module test_hzd_group_overlap;
    localparam int DEPTH = 5;
    localparam int TAG_W = 6;
    localparam int OFF_W = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grp_end = 1'b0;
    logic st_valid = 1'b0, ld_valid = 1'b0;
    logic [TAG_W-1:0] st_off_tag = '0, st_base_tag = '0, ld_off_tag = '0, ld_base_tag = '0;
    logic st_off_const = 1'b0, ld_off_const = 1'b0;
    logic [OFF_W-1:0] st_off_val = '0, ld_off_val = '0;
    logic [2:0] st_size = '0, ld_size = '0;
    logic noop_hazard, ovf_flag;
    logic [CNT_W-1:0] store_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hzd_group_overlap #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OFF_W(OFF_W)) i_hzd_group_overlap (
        .clk(clk), .rst_n(rst_n), .grp_end(grp_end),
        .st_valid(st_valid), .st_off_tag(st_off_tag), .st_base_tag(st_base_tag),
        .st_off_const(st_off_const), .st_off_val(st_off_val), .st_size(st_size),
        .ld_valid(ld_valid), .ld_off_tag(ld_off_tag), .ld_base_tag(ld_base_tag),
        .ld_off_const(ld_off_const), .ld_off_val(ld_off_val), .ld_size(ld_size),
        .noop_hazard(noop_hazard), .ovf_flag(ovf_flag), .store_cnt(store_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_st(input int ot, input int bt, input bit c, input int off, input int sz);
        st_off_tag = TAG_W'(ot); st_base_tag = TAG_W'(bt); st_off_const = c;
        st_off_val = OFF_W'(off); st_size = 3'(sz);
    endtask

    task automatic set_ld(input int ot, input int bt, input bit c, input int off, input int sz);
        ld_off_tag = TAG_W'(ot); ld_base_tag = TAG_W'(bt); ld_off_const = c;
        ld_off_val = OFF_W'(off); ld_size = 3'(sz);
    endtask

    task automatic store(input int ot, input int bt, input bit c, input int off, input int sz);
        @(negedge clk);
        set_st(ot, bt, c, off, sz);
        st_valid = 1'b1;
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic probe(input string req, input int ot, input int bt, input bit c,
                         input int off, input int sz, input bit exp);
        @(negedge clk);
        set_ld(ot, bt, c, off, sz);
        ld_valid = 1'b1;
        #1;
        chk(req, int'(noop_hazard), int'(exp));
        ld_valid = 1'b0;
    endtask

    task automatic end_group();
        @(negedge clk);
        grp_end = 1'b1;
        @(posedge clk); #1;
        grp_end = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 cnt after reset", int'(store_cnt), 0);
        chk("R10 ovf after reset", int'(ovf_flag), 0);
        probe("R7 load with empty list", 1, 2, 1'b0, 0, 0, 1'b0);
    endtask

    task automatic t_tags();
        store(3, 7, 1'b0, 0, 2);
        @(negedge clk);
        chk("R10 cnt after one store", int'(store_cnt), 1);
        probe("R1 same order", 3, 7, 1'b0, 0, 0, 1'b1);
        probe("R2 swapped", 7, 3, 1'b0, 0, 0, 1'b1);
        probe("R11 one tag differs", 3, 8, 1'b0, 0, 0, 1'b0);
        @(negedge clk);
        set_ld(3, 7, 1'b0, 0, 0);
        ld_valid = 1'b0;
        #1;
        chk("R7 matching fields but no load", int'(noop_hazard), 0);
        end_group();
    endtask

    task automatic t_ranges();
        store(20, 5, 1'b1, 8, 2);                  // bytes 8..11
        probe("R3 store below, overlap", 21, 5, 1'b1, 11, 0, 1'b1);
        probe("R11 touching above", 21, 5, 1'b1, 12, 0, 1'b0);
        probe("R4 load below, touching", 21, 5, 1'b1, 6, 1, 1'b0);
        probe("R4 load below, overlap", 21, 5, 1'b1, 6, 2, 1'b1);
        probe("R4 equal offsets", 21, 5, 1'b1, 8, 0, 1'b1);
        probe("R11 load offset not constant", 21, 5, 1'b0, 9, 0, 1'b0);
        probe("R11 base differs", 21, 6, 1'b1, 9, 0, 1'b0);
        end_group();
        store(22, 9, 1'b1, 32, 4);                 // 16 bytes 32..47
        store(23, 9, 1'b1, 64, 3);                 // 8 bytes 64..71
        probe("R5 16-byte last byte", 24, 9, 1'b1, 47, 0, 1'b1);
        probe("R5 16-byte past end", 24, 9, 1'b1, 48, 0, 1'b0);
        probe("R5 8-byte last byte", 24, 9, 1'b1, 71, 0, 1'b1);
        probe("R5 8-byte past end", 24, 9, 1'b1, 72, 0, 1'b0);
        end_group();
    endtask

    task automatic t_clear();
        store(10, 11, 1'b0, 0, 0);
        end_group();
        @(negedge clk);
        chk("R6 cnt after group end", int'(store_cnt), 0);
        probe("R6 old store forgotten", 10, 11, 1'b0, 0, 0, 1'b0);
        @(negedge clk);
        set_st(12, 13, 1'b0, 0, 0);
        st_valid = 1'b1; grp_end = 1'b1;
        @(posedge clk); #1;
        st_valid = 1'b0; grp_end = 1'b0;
        @(negedge clk);
        chk("R6 store with group end dropped", int'(store_cnt), 0);
        probe("R6 dropped store unseen", 12, 13, 1'b0, 0, 0, 1'b0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        set_st(30, 31, 1'b0, 0, 0);
        set_ld(30, 31, 1'b0, 0, 0);
        st_valid = 1'b1; ld_valid = 1'b1;
        #1;
        chk("R9 same-cycle store unseen", int'(noop_hazard), 0);
        @(posedge clk); #1;
        st_valid = 1'b0; ld_valid = 1'b0;
        probe("R9 store seen next cycle", 30, 31, 1'b0, 0, 0, 1'b1);
        end_group();
    endtask

    task automatic t_overflow();
        for (int k = 0; k < DEPTH; k++) store(k + 1, 50, 1'b0, 0, 0);
        @(negedge clk);
        chk("R8 cnt at full", int'(store_cnt), DEPTH);
        chk("R8 no ovf at full", int'(ovf_flag), 0);
        @(negedge clk);
        set_st(40, 41, 1'b0, 0, 0);
        set_ld(1, 50, 1'b0, 0, 0);
        st_valid = 1'b1; ld_valid = 1'b1;
        #1;
        chk("R8 first entry hit while full", int'(noop_hazard), 1);
        @(posedge clk); #1;
        st_valid = 1'b0; ld_valid = 1'b0;
        @(negedge clk);
        chk("R8 cnt unchanged after drop", int'(store_cnt), DEPTH);
        chk("R8 ovf set", int'(ovf_flag), 1);
        probe("R8 dropped store unseen", 40, 41, 1'b0, 0, 0, 1'b0);
        probe("R8 last entry hit", DEPTH, 50, 1'b0, 0, 0, 1'b1);
        end_group();
        @(negedge clk);
        chk("R6 ovf cleared by group end", int'(ovf_flag), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_tags();
        t_ranges();
        t_clear();
        t_same_cycle();
        t_overflow();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule